// File: doc/BRIEF.md
# Vectored Interrupt Sequencing Unit

This unit sits next to the control logic of a simple multicycle processor and decides when an interrupt is taken and where its handler starts. It watches a bank of device request lines and a nonmaskable request. It looks at them only when the processor signals that an instruction has fully completed. When a request qualifies, the unit runs a fixed sequence of steps. First it asks the processor to save the interrupted program's context and waits for that to finish. It then clears the interrupt-enable flag so that maskable sources cannot nest. Next it reads the handler address from a vector table in low memory, indexed by the winning source's ID, and asks the processor to load that address into its program counter.

After the handler's return strobe, the unit asks the processor to restore the saved context. When that completes, the unit writes the enable flag back to the value it held before entry. The unit then goes idle, so any request still pending is taken at the next instruction boundary in the same way. The unit serves one level of interrupt at a time. Anything raised while a handler runs waits until that handler has returned.

Top module: `intSeqUnit`

## Requirements
- R1: A request is considered only in a cycle where `instBoundary` is high while the unit is idle. `saveReq` rises in the cycle after that boundary, and with no boundary the unit stays idle whatever the requests are.
- R2: `saveReq` stays high until `saveDone` is seen high at a clock edge. Until then `ack`, `vecRdEn` and `pcLoad` stay low.
- R3: Source IDs are fixed as follows. The nonmaskable source is ID 0. `devReq[i]` is ID i+1. The nonmaskable request beats every device, and among devices the lowest ID wins.
- R4: While `intEnable` is low, device requests are not taken and stay pending. The nonmaskable request is taken whatever the value of `intEnable`.
- R5: In the cycle after the save completes, `ack` is high for exactly one cycle. In that cycle `ackId` is the winning ID, `vecRdEn` is high and `vecAddr` is the winning ID zero-extended (table base 0).
- R6: In the cycle after the vector read, `pcLoad` is high for one cycle and `pcLoadAddr` equals `vecData`. The table word is expected one cycle after `vecRdEn`.
- R7: While the save is in progress, `ieWr` is high and `ieVal` is 0, so the enable flag is cleared on entry.
- R8: While a handler runs, instruction boundaries and new requests do not start another save.
- R9: A `retStrobe` during the handler raises `restoreReq`, which holds until `restoreDone`. In the cycle where `restoreDone` is high, `ieWr` is high and `ieVal` equals the `intEnable` value sampled at the boundary that started the interrupt.
- R10: After the restore completes, a request that is still pending is serviced at the next instruction boundary by the same sequence.
- R11: After reset, all outputs are low and the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | NUM_DEV | Level requests from devices; bit i is ID i+1 |
| nmiReq | input | 1 | Nonmaskable request level, ID 0 |
| intEnable | input | 1 | Current value of the processor's interrupt-enable flag |
| instBoundary | input | 1 | Pulses when an instruction has fully completed |
| retStrobe | input | 1 | Pulses when the handler executes its return |
| saveReq | output | 1 | Asks the processor to save context |
| saveDone | input | 1 | Context save finished |
| ack | output | 1 | One-cycle acknowledge of the taken source |
| ackId | output | ID_W | ID of the acknowledged source |
| vecRdEn | output | 1 | Vector table read strobe |
| vecAddr | output | ADDR_W | Vector table word address |
| vecData | input | ADDR_W | Handler address returned one cycle after the read |
| pcLoad | output | 1 | Asks the processor to load its program counter |
| pcLoadAddr | output | ADDR_W | Handler address to load |
| ieWr | output | 1 | Write strobe for the enable flag |
| ieVal | output | 1 | Value to write into the enable flag |
| restoreReq | output | 1 | Asks the processor to restore context |
| restoreDone | input | 1 | Context restore finished |

## Verification
The assertions take for granted that `saveDone` is raised only while `saveReq` is high and `restoreDone` only while `restoreReq` is high. They also assume that `instBoundary` and `retStrobe` are single-cycle pulses, and that the vector word arrives exactly one cycle after the read strobe. The stimulus holds to this: a memory model answers every read on the following edge, and each handshake is answered only after the bench has seen the matching request high. The bench also delays answers by several cycles to show that the unit waits. Requests stay at a stable level across each sequence, and the bench clears a request only after it has been serviced.

// File: rtl/intSeqPkg.sv
package intSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SAVE     = 3'd1,
    ST_VECREAD  = 3'd2,
    ST_LOADPC   = 3'd3,
    ST_HANDLER  = 3'd4,
    ST_RESTORE  = 3'd5
  } seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // latch winning ID and current enable flag
    logic vecRead;    // drive the vector table read
    logic pcDrive;    // drive the handler address to the PC
    logic ieClear;    // force the enable flag low
    logic ieRestore;  // write the saved enable flag back
  } seqStrobe_t;

endpackage

// File: rtl/intSeqCtrl.sv
module intSeqCtrl
  import intSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hit,
  input  logic       instBoundary,
  input  logic       saveDone,
  input  logic       retStrobe,
  input  logic       restoreDone,
  output logic       saveReq,
  output logic       restoreReq,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (instBoundary && hit) stateNext = ST_SAVE;
      ST_SAVE:    if (saveDone) stateNext = ST_VECREAD;
      ST_VECREAD: stateNext = ST_LOADPC;
      ST_LOADPC:  stateNext = ST_HANDLER;
      ST_HANDLER: if (retStrobe) stateNext = ST_RESTORE;
      ST_RESTORE: if (restoreDone) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe           = '0;
    strobe.capture   = (state == ST_IDLE) && instBoundary && hit;
    strobe.vecRead   = (state == ST_VECREAD);
    strobe.pcDrive   = (state == ST_LOADPC);
    strobe.ieClear   = (state == ST_SAVE);
    strobe.ieRestore = (state == ST_RESTORE) && restoreDone;
  end

  assign saveReq    = (state == ST_SAVE);
  assign restoreReq = (state == ST_RESTORE);

  // R1: idle only leaves on a boundary
  p_wait_boundary_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !instBoundary) |=> (state == ST_IDLE));

  // R2: save handshake is waited for
  p_hold_save_r2: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && !saveDone) |=> saveReq);

  // R8: handler level is left only through the return strobe
  p_no_nest_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HANDLER && !retStrobe) |=> (state == ST_HANDLER));

  // R9: restore handshake is waited for
  p_hold_restore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (restoreReq && !restoreDone) |=> restoreReq);

endmodule

// File: rtl/intSeqPath.sv
module intSeqPath
  import intSeqPkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int ADDR_W  = 12,
  localparam int ID_W   = $clog2(NUM_DEV + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic               nmiReq,
  input  logic               intEnable,
  input  seqStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  vecData,
  output logic               hit,
  output logic [ID_W-1:0]    ackId,
  output logic               ack,
  output logic               vecRdEn,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               pcLoad,
  output logic [ADDR_W-1:0]  pcLoadAddr,
  output logic               ieWr,
  output logic               ieVal
);

  logic [ID_W-1:0] devPick, idNext, idReg;
  logic            devFound, savedIe;

  // lowest set bit wins; bit i maps to ID i+1
  always_comb begin
    devPick  = '0;
    devFound = 1'b0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (devReq[i] && !devFound) begin
        devFound = 1'b1;
        devPick  = ID_W'(i + 1);
      end
    end
  end

  assign hit    = nmiReq || (intEnable && devFound);
  assign idNext = nmiReq ? '0 : devPick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg   <= '0;
      savedIe <= 1'b0;
    end else if (strobe.capture) begin
      idReg   <= idNext;
      savedIe <= intEnable;
    end
  end

  assign ack        = strobe.vecRead;
  assign vecRdEn    = strobe.vecRead;
  assign ackId      = strobe.vecRead ? idReg : '0;
  assign vecAddr    = strobe.vecRead ? ADDR_W'(idReg) : '0;
  assign pcLoad     = strobe.pcDrive;
  assign pcLoadAddr = strobe.pcDrive ? vecData : '0;
  assign ieWr       = strobe.ieClear || strobe.ieRestore;
  assign ieVal      = strobe.ieRestore && savedIe;

  // R4: a maskable source is only captured with the flag set
  p_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !nmiReq) |-> intEnable);

  // R3: the nonmaskable source always gets ID 0
  p_nmi_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && nmiReq) |=> (idReg == '0));

  // R7: enable flag is never written high while entering
  p_clear_on_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ieClear |-> !ieVal);

endmodule

// File: rtl/intSeqUnit.sv
module intSeqUnit
  import intSeqPkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int ADDR_W  = 12,
  localparam int ID_W   = $clog2(NUM_DEV + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic               nmiReq,
  input  logic               intEnable,
  input  logic               instBoundary,
  input  logic               retStrobe,
  output logic               saveReq,
  input  logic               saveDone,
  output logic               ack,
  output logic [ID_W-1:0]    ackId,
  output logic               vecRdEn,
  output logic [ADDR_W-1:0]  vecAddr,
  input  logic [ADDR_W-1:0]  vecData,
  output logic               pcLoad,
  output logic [ADDR_W-1:0]  pcLoadAddr,
  output logic               ieWr,
  output logic               ieVal,
  output logic               restoreReq,
  input  logic               restoreDone
);

  seqStrobe_t strobe;
  logic       hit;

  intSeqCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hit          (hit),
    .instBoundary (instBoundary),
    .saveDone     (saveDone),
    .retStrobe    (retStrobe),
    .restoreDone  (restoreDone),
    .saveReq      (saveReq),
    .restoreReq   (restoreReq),
    .strobe       (strobe)
  );

  intSeqPath #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .devReq     (devReq),
    .nmiReq     (nmiReq),
    .intEnable  (intEnable),
    .strobe     (strobe),
    .vecData    (vecData),
    .hit        (hit),
    .ackId      (ackId),
    .ack        (ack),
    .vecRdEn    (vecRdEn),
    .vecAddr    (vecAddr),
    .pcLoad     (pcLoad),
    .pcLoadAddr (pcLoadAddr),
    .ieWr       (ieWr),
    .ieVal      (ieVal)
  );

  // R6: PC load follows a vector read
  p_pc_after_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> $past(vecRdEn));

  // R5: acknowledge is a single-cycle pulse
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R2: vector read comes straight after a completed save
  p_read_after_save_r2: assert property (@(posedge clk) disable iff (!rstN)
    vecRdEn |-> $past(saveReq && saveDone));

endmodule

// File: tb/tb_intSeqUnit.sv
`timescale 1ns/1ps
module tb_intSeqUnit;
  localparam int NUM_DEV = 8;
  localparam int ADDR_W  = 12;
  localparam int ID_W    = $clog2(NUM_DEV + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_DEV-1:0] devReq = '0;
  logic nmiReq = 1'b0, intEnable = 1'b0, instBoundary = 1'b0, retStrobe = 1'b0;
  logic saveDone = 1'b0, restoreDone = 1'b0;
  logic saveReq, ack, vecRdEn, pcLoad, ieWr, ieVal, restoreReq;
  logic [ID_W-1:0]   ackId;
  logic [ADDR_W-1:0] vecAddr, pcLoadAddr;
  logic [ADDR_W-1:0] vecData = '0;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intSeqUnit #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .devReq(devReq), .nmiReq(nmiReq),
    .intEnable(intEnable), .instBoundary(instBoundary), .retStrobe(retStrobe),
    .saveReq(saveReq), .saveDone(saveDone), .ack(ack), .ackId(ackId),
    .vecRdEn(vecRdEn), .vecAddr(vecAddr), .vecData(vecData),
    .pcLoad(pcLoad), .pcLoadAddr(pcLoadAddr), .ieWr(ieWr), .ieVal(ieVal),
    .restoreReq(restoreReq), .restoreDone(restoreDone)
  );

  function automatic logic [ADDR_W-1:0] tableWord(input logic [ADDR_W-1:0] a);
    return ADDR_W'(12'h400 + a * 3);
  endfunction

  // vector table model: word returned one cycle after the read strobe
  always @(posedge clk) if (vecRdEn) vecData <= tableWord(vecAddr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // One full interrupt: boundary, save, vector, PC load, handler, restore
  task automatic serviceOne(input int expId, input logic expIe);
    instBoundary = 1'b1;
    tick();
    instBoundary = 1'b0;
    check("R1 saveReq after boundary", saveReq, 1);
    check("R7 ieWr during save", ieWr, 1);
    check("R7 ieVal during save", ieVal, 0);
    tick();
    tick();
    check("R2 saveReq held", saveReq, 1);
    check("R2 no ack before save done", ack, 0);
    saveDone = 1'b1;
    tick();
    saveDone = 1'b0;
    check("R5 ack", ack, 1);
    check("R3 ackId", ackId, expId);
    check("R5 vecRdEn", vecRdEn, 1);
    check("R5 vecAddr", vecAddr, expId);
    tick();
    check("R5 ack single cycle", ack, 0);
    check("R6 pcLoad", pcLoad, 1);
    check("R6 pcLoadAddr", pcLoadAddr, tableWord(ADDR_W'(expId)));
    tick();
    check("R6 pcLoad single cycle", pcLoad, 0);
    instBoundary = 1'b1;
    tick();
    instBoundary = 1'b0;
    check("R8 no save while in handler", saveReq, 0);
    retStrobe = 1'b1;
    tick();
    retStrobe = 1'b0;
    check("R9 restoreReq", restoreReq, 1);
    check("R9 no flag write before done", ieWr, 0);
    tick();
    check("R9 restoreReq held", restoreReq, 1);
    restoreDone = 1'b1;
    #1;
    check("R9 ieWr on restore", ieWr, 1);
    check("R9 ieVal restored", ieVal, expIe);
    tick();
    restoreDone = 1'b0;
    check("R9 restoreReq dropped", restoreReq, 0);
  endtask

  task automatic testReset();
    check("R11 saveReq", saveReq, 0);
    check("R11 ack", ack, 0);
    check("R11 pcLoad", pcLoad, 0);
    check("R11 restoreReq", restoreReq, 0);
    check("R11 ieWr", ieWr, 0);
    check("R11 vecRdEn", vecRdEn, 0);
  endtask

  task automatic testNoBoundary();
    devReq = 8'b0000_0100;
    intEnable = 1'b1;
    nmiReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      check("R1 idle without boundary", saveReq, 0);
    end
    nmiReq = 1'b0;
  endtask

  task automatic testSingle();
    devReq = 8'b0000_0100;
    intEnable = 1'b1;
    serviceOne(3, 1'b1);
    devReq = '0;
  endtask

  task automatic testLowestWins();
    devReq = 8'b0011_0010;
    intEnable = 1'b1;
    serviceOne(2, 1'b1);
    devReq = 8'b0011_0000;
    tick();
    check("R10 stays idle until boundary", saveReq, 0);
    serviceOne(5, 1'b1);  // R10 pending request taken next
    devReq = 8'b0010_0000;
    serviceOne(6, 1'b1);
    devReq = '0;
  endtask

  task automatic testMask();
    devReq = 8'b1000_0001;
    intEnable = 1'b0;
    instBoundary = 1'b1;
    tick();
    instBoundary = 1'b0;
    check("R4 masked request not taken", saveReq, 0);
    tick();
    check("R4 still idle", saveReq, 0);
    nmiReq = 1'b1;
    serviceOne(0, 1'b0);
    nmiReq = 1'b0;
    intEnable = 1'b1;
    serviceOne(1, 1'b1);  // R4 masked request remained pending
    devReq = '0;
  endtask

  task automatic testNmiBeatsDevices();
    devReq = 8'b0000_0001;
    intEnable = 1'b1;
    nmiReq = 1'b1;
    serviceOne(0, 1'b1);  // R3
    nmiReq = 1'b0;
    devReq = 8'b1000_0000;
    serviceOne(8, 1'b1);  // R3 top device maps to ID 8
    devReq = '0;
  endtask

  initial begin
    repeat (3) tick();
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testNoBoundary();
    testSingle();
    testLowestWins();
    testMask();
    testNmiBeatsDevices();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule